// File: doc/BRIEF.md
# Nanosecond Real-Time Clock with Alarm Interrupt

This block keeps a 64-bit time value in nanoseconds. The value moves forward by a fixed step on every clock edge. Software reaches it through a plain 32-bit register port with word address, write strobe, write data, read strobe and read data. Software can read either half of the time and overwrite either half while the clock keeps running. It can also load a 64-bit alarm time, disarm a pending alarm and acknowledge the interrupt.

Writing the upper alarm word only stores it. Writing the lower alarm word stores it and evaluates the complete alarm at once. If the alarm time is at or behind the current time, the alarm fires on that write. Otherwise the alarm is armed and fires when the time reaches it. A firing clears the armed flag and sets a sticky pending flag. The interrupt line is the pending flag gated by a one-bit enable.

Top module: `ns_rtc_alarm`

## Requirements
- R1: After reset the time equals the parameter RESET_TIME. Each clock edge without a time write adds STEP to it.
- R2: A write to offset 0x00 replaces bits 31:0 of the time, and a write to offset 0x04 replaces bits 63:32. The other half keeps its present value. On the write edge the time takes the written value with no step added, and it advances from that value on the following edges.
- R3: A read with the read strobe high returns its data on bus_rdata one cycle later, and bus_rdata is 0 in any cycle that follows no read. The readable words are: 0x00 time low, 0x04 time high, 0x08 alarm low, 0x0C alarm high, 0x10 enable in bit 0, and 0x18 armed flag in bit 0. A time read returns the time as it was before the edge that captures it.
- R4: A write to offset 0x0C changes only alarm bits 63:32. It neither arms nor fires the alarm.
- R5: A write to offset 0x08 loads alarm bits 31:0 and then evaluates the alarm. If the new 64-bit alarm is less than or equal to the current time, the pending flag sets and the armed flag stays clear on that edge. Otherwise the armed flag sets.
- R6: While armed, the alarm fires on the first edge at which the time, compared as a 64-bit unsigned value, is greater than or equal to the alarm. Firing clears the armed flag and sets the pending flag, so a STEP larger than 1 cannot step over the alarm.
- R7: Any write to offset 0x14 clears the armed flag and leaves the pending flag as it was.
- R8: Any write to offset 0x1C clears the pending flag. If the alarm fires on that same edge, the pending flag stays set.
- R9: irq is high exactly when the pending flag and the enable are both set. The enable is bit 0 of a write to offset 0x10, the other bits are ignored, and irq follows the enable in the cycle after the write.
- R10: Reads of 0x14, 0x1C, unused offsets and addresses with bits 1:0 not zero return 0. Writes to unused offsets or unaligned addresses change nothing.
- R11: Reset clears the alarm value, the armed flag, the pending flag and the enable, so irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data |
| irq | output | 1 | Level interrupt, pending gated by enable |

## Verification
The hardest cases to reach from the ports depend on the exact edge on which an armed alarm fires: an acknowledge that coincides with a firing, and a step size that overshoots the alarm time. The bench sets the time to a known value, arms the alarm one cycle later, and counts idle cycles from that point. This lets it place the acknowledge write, or an irq sample, on the exact firing edge or the one just before it. It uses a step of 3 and an alarm offset that is not a multiple of 3 to show that an overshoot still fires the alarm.

// File: rtl/ns_rtc_pkg.sv
package ns_rtc_pkg;

   // Word offsets of the register port (byte addresses)
   localparam logic [15:0] OFS_TIME_LO = 16'h0000;
   localparam logic [15:0] OFS_TIME_HI = 16'h0004;
   localparam logic [15:0] OFS_ALM_LO  = 16'h0008;
   localparam logic [15:0] OFS_ALM_HI  = 16'h000C;
   localparam logic [15:0] OFS_IRQ_EN  = 16'h0010;
   localparam logic [15:0] OFS_DISARM  = 16'h0014;
   localparam logic [15:0] OFS_STATUS  = 16'h0018;
   localparam logic [15:0] OFS_ACK     = 16'h001C;

   typedef enum logic [3:0] {
      RS_TIME_LO = 4'd0,
      RS_TIME_HI = 4'd1,
      RS_ALM_LO  = 4'd2,
      RS_ALM_HI  = 4'd3,
      RS_IRQ_EN  = 4'd4,
      RS_DISARM  = 4'd5,
      RS_STATUS  = 4'd6,
      RS_ACK     = 4'd7,
      RS_NONE    = 4'd15
   } rtc_reg_e;

   typedef struct packed {
      logic time_lo;
      logic time_hi;
      logic alm_lo;
      logic alm_hi;
      logic irq_en;
      logic disarm;
      logic ack;
   } rtc_wr_s;

endpackage

// File: rtl/ns_rtc_regif.sv
module ns_rtc_regif
   import ns_rtc_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output rtc_reg_e          sel,
   output rtc_wr_s           wr
);

   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              in_range;
   logic              aligned;

   assign word    = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);

   generate
      if (WORD_W > 3) begin : g_wide
         assign in_range = (word[WORD_W-1:3] == '0);
      end else begin : g_narrow
         assign in_range = 1'b1;
      end
   endgenerate

   always_comb begin
      if (aligned && in_range)
         sel = rtc_reg_e'({1'b0, word[2:0]});
      else
         sel = RS_NONE;
   end

   always_comb begin
      wr         = '0;
      wr.time_lo = we && (sel == RS_TIME_LO);
      wr.time_hi = we && (sel == RS_TIME_HI);
      wr.alm_lo  = we && (sel == RS_ALM_LO);
      wr.alm_hi  = we && (sel == RS_ALM_HI);
      wr.irq_en  = we && (sel == RS_IRQ_EN);
      wr.disarm  = we && (sel == RS_DISARM);
      wr.ack     = we && (sel == RS_ACK);
   end

endmodule

// File: rtl/ns_rtc_counter.sv
module ns_rtc_counter #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned STEP       = 1,
   parameter logic [63:0] RESET_TIME = 64'd0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_lo,
   input  logic                load_hi,
   input  logic [DATA_W-1:0]   wdata,
   output logic [2*DATA_W-1:0] time_q
);

   localparam int unsigned CNT_W = 2 * DATA_W;

   logic [CNT_W-1:0] stepped;
   logic [CNT_W-1:0] time_d;

   generate
      if (STEP == 1) begin : g_unit
         assign stepped = time_q + 1'b1;
      end else begin : g_multi
         assign stepped = time_q + CNT_W'(STEP);
      end
   endgenerate

   always_comb begin
      if (load_lo)
         time_d = {time_q[CNT_W-1:DATA_W], wdata};
      else if (load_hi)
         time_d = {wdata, time_q[DATA_W-1:0]};
      else
         time_d = stepped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         time_q <= RESET_TIME[CNT_W-1:0];
      else
         time_q <= time_d;
   end

endmodule

// File: rtl/ns_rtc_alarm_unit.sv
module ns_rtc_alarm_unit
   import ns_rtc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  rtc_wr_s             wr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [2*DATA_W-1:0] time_q,
   output logic [2*DATA_W-1:0] alarm_q,
   output logic                armed_q,
   output logic                pend_q,
   output logic                en_q,
   output logic                irq
);

   localparam int unsigned CNT_W = 2 * DATA_W;

   logic [CNT_W-1:0] alarm_new;
   logic             hit_on_load;
   logic             hit_running;
   logic             fire;

   // Lower half of a low-word write, upper half kept
   assign alarm_new   = {alarm_q[CNT_W-1:DATA_W], wdata};
   assign hit_on_load = wr.alm_lo && (alarm_new <= time_q);
   assign hit_running = armed_q && !wr.alm_lo && !wr.disarm
                        && (time_q >= alarm_q);
   assign fire        = hit_on_load || hit_running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q <= '0;
      end else if (wr.alm_lo) begin
         alarm_q <= alarm_new;
      end else if (wr.alm_hi) begin
         alarm_q <= {wdata, alarm_q[DATA_W-1:0]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed_q <= 1'b0;
      else if (wr.alm_lo)
         armed_q <= !hit_on_load;
      else if (wr.disarm || hit_running)
         armed_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (fire)
         pend_q <= 1'b1;
      else if (wr.ack)
         pend_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (wr.irq_en)
         en_q <= wdata[0];
   end

   assign irq = pend_q & en_q;

endmodule

// File: rtl/ns_rtc_alarm.sv
module ns_rtc_alarm
   import ns_rtc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned STEP       = 1,
   parameter logic [63:0] RESET_TIME = 64'd0,
   parameter bit          READ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int unsigned CNT_W = 2 * DATA_W;

   generate
      if (DATA_W != 32) begin : g_chk_data
         $error("ns_rtc_alarm: DATA_W must be 32");
      end
      if (ADDR_W < 5 || ADDR_W > 16) begin : g_chk_addr
         $error("ns_rtc_alarm: ADDR_W must lie in 5..16");
      end
      if (STEP == 0) begin : g_chk_step
         $error("ns_rtc_alarm: STEP must be nonzero");
      end
   endgenerate

   rtc_reg_e         sel;
   rtc_wr_s          wr;
   logic [CNT_W-1:0] time_q;
   logic [CNT_W-1:0] alarm_q;
   logic             armed_q;
   logic             pend_q;
   logic             en_q;
   logic [DATA_W-1:0] rd_val;

   ns_rtc_regif #(.ADDR_W(ADDR_W)) u_regif (
      .addr (bus_addr),
      .we   (bus_we),
      .sel  (sel),
      .wr   (wr)
   );

   ns_rtc_counter #(
      .DATA_W     (DATA_W),
      .STEP       (STEP),
      .RESET_TIME (RESET_TIME)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_lo (wr.time_lo),
      .load_hi (wr.time_hi),
      .wdata   (bus_wdata),
      .time_q  (time_q)
   );

   ns_rtc_alarm_unit #(.DATA_W(DATA_W)) u_alarm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr),
      .wdata   (bus_wdata),
      .time_q  (time_q),
      .alarm_q (alarm_q),
      .armed_q (armed_q),
      .pend_q  (pend_q),
      .en_q    (en_q),
      .irq     (irq)
   );

   always_comb begin
      rd_val = '0;
      case (sel)
         RS_TIME_LO: rd_val = time_q[DATA_W-1:0];
         RS_TIME_HI: rd_val = time_q[CNT_W-1:DATA_W];
         RS_ALM_LO:  rd_val = alarm_q[DATA_W-1:0];
         RS_ALM_HI:  rd_val = alarm_q[CNT_W-1:DATA_W];
         RS_IRQ_EN:  rd_val = {{(DATA_W-1){1'b0}}, en_q};
         RS_STATUS:  rd_val = {{(DATA_W-1){1'b0}}, armed_q};
         default:    rd_val = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bus_rdata <= '0;
            else
               bus_rdata <= bus_re ? rd_val : '0;
         end
      end else begin : g_rd_comb
         assign bus_rdata = bus_re ? rd_val : '0;
      end
   endgenerate

endmodule

// File: rtl/ns_rtc_chk.sv
module ns_rtc_chk
   import ns_rtc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned STEP     = 1,
   parameter bit          READ_REG = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic                bus_re,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [2*DATA_W-1:0] time_q,
   input logic [2*DATA_W-1:0] alarm_q,
   input logic                armed_q,
   input logic                pend_q
);

   localparam int unsigned CNT_W = 2 * DATA_W;

   logic hit_time, hit_alm_lo, hit_alm_hi, hit_disarm, hit_ack, readable;

   assign hit_time   = (bus_addr == OFS_TIME_LO[ADDR_W-1:0])
                    || (bus_addr == OFS_TIME_HI[ADDR_W-1:0]);
   assign hit_alm_lo = (bus_addr == OFS_ALM_LO[ADDR_W-1:0]);
   assign hit_alm_hi = (bus_addr == OFS_ALM_HI[ADDR_W-1:0]);
   assign hit_disarm = (bus_addr == OFS_DISARM[ADDR_W-1:0]);
   assign hit_ack    = (bus_addr == OFS_ACK[ADDR_W-1:0]);
   assign readable   = hit_time || hit_alm_lo || hit_alm_hi
                    || (bus_addr == OFS_IRQ_EN[ADDR_W-1:0])
                    || (bus_addr == OFS_STATUS[ADDR_W-1:0]);

   // R1
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && hit_time) |=> time_q == $past(time_q) + CNT_W'(STEP));

   // R6
   alarm_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && time_q >= alarm_q && !(bus_we && (hit_disarm || hit_alm_lo)))
      |=> (pend_q && !armed_q));

   // R7
   disarm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_disarm) |=> !armed_q);

   // R4
   hi_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_alm_hi && !armed_q) |=> (!armed_q && $stable(pend_q)));

   // R8
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !(bus_we && hit_ack)) |=> pend_q);

   generate
      if (READ_REG) begin : g_rd_chk
         // R10
         rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_re && readable) |=> bus_rdata == '0);
      end else begin : g_rd_chk_comb
         // R10
         rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_re && readable) |-> bus_rdata == '0);
      end
   endgenerate

endmodule

bind ns_rtc_alarm ns_rtc_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .STEP     (STEP),
   .READ_REG (READ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_rdata (bus_rdata),
   .time_q    (time_q),
   .alarm_q   (alarm_q),
   .armed_q   (armed_q),
   .pend_q    (pend_q)
);

// File: tb/sim_ns_rtc_alarm.sv
`timescale 1ns/1ps
module sim_ns_rtc_alarm;

   localparam int unsigned AW   = 6;
   localparam int unsigned STEP = 3;
   localparam logic [63:0] RST_T = 64'h0000_00AB_0000_0010;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_re = 1'b0;
   logic [31:0]   bus_rdata;
   logic          irq;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   ns_rtc_alarm #(
      .ADDR_W     (AW),
      .STEP       (STEP),
      .RESET_TIME (RST_T)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_re    (bus_re),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h0C, 32'h0000_0100, 32'h0, 4'd4},
      '{1'b0, 8'h0C, 32'h0,         32'h0000_0100, 4'd3},
      '{1'b0, 8'h18, 32'h0,         32'h0, 4'd4},
      '{1'b1, 8'h08, 32'h1234_5678, 32'h0, 4'd5},
      '{1'b0, 8'h08, 32'h0,         32'h1234_5678, 4'd3},
      '{1'b0, 8'h18, 32'h0,         32'h1, 4'd5},
      '{1'b1, 8'h14, 32'h0,         32'h0, 4'd7},
      '{1'b0, 8'h18, 32'h0,         32'h0, 4'd7},
      '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 4'd9},
      '{1'b0, 8'h10, 32'h0,         32'h1, 4'd9},
      '{1'b1, 8'h10, 32'h0000_0002, 32'h0, 4'd9},
      '{1'b0, 8'h10, 32'h0,         32'h0, 4'd9},
      '{1'b0, 8'h14, 32'h0,         32'h0, 4'd10},
      '{1'b0, 8'h1C, 32'h0,         32'h0, 4'd10},
      '{1'b1, 8'h24, 32'h0000_DEAD, 32'h0, 4'd10},
      '{1'b0, 8'h24, 32'h0,         32'h0, 4'd10},
      '{1'b1, 8'h0A, 32'h0000_0055, 32'h0, 4'd10},
      '{1'b0, 8'h08, 32'h0,         32'h1234_5678, 4'd10}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // All tasks start and end just after a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a[AW-1:0];
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a[AW-1:0];
      bus_re   = 1'b1;
      @(negedge clk);
      d        = bus_rdata;
      bus_re   = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all) act=timeout exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      idle(3);
      // R11 reset state at the pins
      check("R11 irq in reset", irq, 0);
      check("R3 rdata in reset", bus_rdata, 0);
      rst_n = 1'b1;
      rd(8'h00, v); check("R1 time lo after reset", v, RST_T[31:0]);
      rd(8'h04, v); check("R1 time hi after reset", v, RST_T[63:32]);
      rd(8'h08, v); check("R11 alarm lo", v, 0);
      rd(8'h0C, v); check("R11 alarm hi", v, 0);
      rd(8'h10, v); check("R11 enable", v, 0);
      rd(8'h18, v); check("R11 armed", v, 0);
      idle(1);
      check("R3 rdata idle", bus_rdata, 0);

      // R1 stepping after a load
      wr(8'h00, 32'h100); idle(4);
      rd(8'h00, v); check("R1 step x4", v, 32'h100 + 4*STEP);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) begin
            wr(VEC[i].addr, VEC[i].data);
         end else begin
            rd(VEC[i].addr, v);
            n_run++;
            if (v !== VEC[i].exp) begin
               n_fail++;
               $display("FAIL R%0d vec %0d act=%h exp=%h", VEC[i].req, i, v, VEC[i].exp);
            end
         end
      end

      // R2 carry from low half into high half
      wr(8'h04, 32'h12); wr(8'h00, 32'hFFFF_FFF0); idle(6);
      rd(8'h04, v); check("R2 carry hi", v, 32'h13);
      rd(8'h00, v); check("R2 carry lo", v, 32'h5);
      // R2 high write keeps low half
      wr(8'h00, 32'd100); wr(8'h04, 32'h7);
      rd(8'h00, v); check("R2 lo kept", v, 32'd100);
      rd(8'h04, v); check("R2 hi loaded", v, 32'h7);

      // R4 high alarm write to a past value does not fire
      wr(8'h0C, 32'h0); wr(8'h10, 32'h1);
      check("R4 no fire on hi write", irq, 0);
      rd(8'h18, v); check("R4 not armed", v, 0);
      // R5 past alarm fires on the low write
      wr(8'h08, 32'h5);
      check("R5 past alarm irq", irq, 1);
      rd(8'h18, v); check("R5 armed clear after fire", v, 0);

      // R7 disarm keeps pending
      wr(8'h0C, 32'h8); wr(8'h08, 32'h0);
      rd(8'h18, v); check("R5 future alarm armed", v, 1);
      wr(8'h14, 32'h0);
      rd(8'h18, v); check("R7 disarmed", v, 0);
      check("R7 pending kept", irq, 1);
      wr(8'h1C, 32'h0);
      check("R8 ack clears", irq, 0);

      // R9 mask
      wr(8'h10, 32'h0); wr(8'h0C, 32'h0); wr(8'h08, 32'h1);
      check("R9 masked", irq, 0);
      wr(8'h10, 32'h1);
      check("R9 unmasked", irq, 1);
      wr(8'h1C, 32'h0);

      // R5 equal alarm fires
      wr(8'h04, 32'h0); wr(8'h00, 32'd1000); wr(8'h08, 32'd1000);
      check("R5 equal fires", irq, 1);
      wr(8'h1C, 32'h0);

      // R6 step overshoot: fire at 2033 >= 2031
      wr(8'h00, 32'd2000); wr(8'h08, 32'd2031);
      check("R6 armed no irq", irq, 0);
      idle(10);
      check("R6 edge before fire", irq, 0);
      idle(1);
      check("R6 fire", irq, 1);
      rd(8'h18, v); check("R6 armed cleared", v, 0);
      wr(8'h1C, 32'h0);

      // R8 ack on the firing edge
      wr(8'h00, 32'd3000); wr(8'h08, 32'd3030);
      idle(9);
      wr(8'h1C, 32'h0);
      check("R8 fire beats ack", irq, 1);
      wr(8'h1C, 32'h0);
      check("R8 second ack", irq, 0);

      // R11 reset mid-run
      wr(8'h08, 32'h0);
      check("R11 irq before reset", irq, 1);
      rst_n = 1'b0;
      idle(1);
      check("R11 irq in reset", irq, 0);
      rst_n = 1'b1;
      rd(8'h00, v); check("R11 time reloaded", v, RST_T[31:0]);
      rd(8'h10, v); check("R11 enable cleared", v, 0);
      rd(8'h08, v); check("R11 alarm cleared", v, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule